// File: doc/BRIEF.md
# Serial Configuration Port with Row-Select Programming

The block is a four-wire serial port that writes and reads back a row-organised configuration store. It is active only while its enable input is held low. In that state a serial clock, a data input and a mode input drive a small command engine, and a serial data output returns register contents. While the enable input is high the port does nothing, and the mode and data inputs are passed through as ordinary logic inputs for the rest of the chip.

The host first shifts a 3-bit command in, then either shifts a target register or fires a one-shot action. The registers are a one-hot row-select register and a wide row data register. The data register can be loaded whole or in its upper or lower half on its own. The actions are: write the data register into every selected row; load the selected rows back into the data register (the AND of all of them when more than one is selected); and load the fixed 8-bit device identifier into a readback register. All shifting is least significant bit first. The output pin changes only on falling serial clock edges, so a host can sample it safely on the rising edge.

Top module: `isp_serial_port`

## Requirements
- R1: While rst_ni is low, every array row, the row-select register and the data register are cleared and sdo_o is 0. After reset, a verify of any single row returns all zeros.
- R2: While ispen_ni is high, sdo_oe_o and sdo_o are 0 and pin_o equals {mode_i, sdi_i}. No register or array row changes, whatever mode_i and sdi_i do. While ispen_ni is low, pin_o is 0 and sdo_oe_o is 1.
- R3: On a rising sclk_i edge with ispen_ni low, the inputs are decoded as follows. mode_i=1 with sdi_i=1 enters command entry. mode_i=0 during command entry shifts sdi_i into the 3-bit command register, LSB first. mode_i=1 with sdi_i=0 latches the command register and executes it. The command codes are 0 no-op, 1 row-select shift, 2 low-half data shift, 3 program, 4 verify, 5 identifier, 6 high-half data shift, 7 full data shift. A no-op changes no register.
- R4: Under command 1, each mode_i=0 edge moves sdi_i into bit 109 of the 110-bit row-select register and shifts it right, so the first bit sent lands in bit 0. Bit r set selects row r.
- R5: Command 7 shifts all 160 data bits (entry at bit 159). Command 2 shifts only bits 79..0 (entry at bit 79). Command 6 shifts only bits 159..80 (entry at bit 159). The half that is not selected keeps its value.
- R6: Executing command 3 writes the data register into every row whose select bit is 1. Other rows keep their contents.
- R7: Executing command 4 loads the data register with the bitwise AND of all selected rows. With no row selected, it loads all ones.
- R8: Executing command 5 loads the identifier 0x0B. The following shifts return it on sdo_o, LSB first, as 1,1,0,1,0,0,0,0.
- R9: sdo_o updates only on falling sclk_i edges. It shows bit 0 of the active register: the command register during command entry, data bit 80 under command 6, and data bit 0 under commands 2 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock |
| ispen_ni | input | 1 | Port enable, active low |
| mode_i | input | 1 | Mode control; ordinary input when the port is disabled |
| sdi_i | input | 1 | Serial data in; ordinary input when the port is disabled |
| sdo_o | output | 1 | Serial data out, updated on falling sclk_i edges |
| sdo_oe_o | output | 1 | Drive enable for the serial output pin |
| pin_o | output | 2 | {mode_i, sdi_i} passed through while disabled, 0 otherwise |

## Verification
On every rising edge, the assertions check the command engine and the registers. They cover the entry into command state and the latching of the shifted command. They cover the right-shift of the row-select register from sdi_i, the isolation of the unselected data half, and the freeze of all state and the quiet output while the port is disabled. Some behaviours are visible only through the scenarios the bench drives, each compared against a bench-side model of the array. These are the contents the array holds after programming, the AND readback over several selected rows, the all-ones result with nothing selected, the identifier bit order, and the falling-edge timing of sdo_o.

// File: rtl/isp_cfg_pkg.sv
`timescale 1ns/1ps
package isp_cfg_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP    = 3'd0,
    CMD_ADDR   = 3'd1,
    CMD_DLO    = 3'd2,
    CMD_PROG   = 3'd3,
    CMD_VERIFY = 3'd4,
    CMD_ID     = 3'd5,
    CMD_DHI    = 3'd6,
    CMD_DALL   = 3'd7
  } cmd_e;
endpackage

// File: rtl/isp_cmd_fsm.sv
`timescale 1ns/1ps
module isp_cmd_fsm
  import isp_cfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_i,
  input  logic sdi_i,
  output logic in_cmd_o,
  output cmd_e cmd_q_o,
  output cmd_e exec_cmd_o,
  output logic exec_o,
  output logic shift_o,
  output logic cmd_bit_o
);
  logic [CMD_W-1:0] cmd_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_sr   <= '0;
      in_cmd_o <= 1'b0;
      cmd_q_o  <= CMD_NOP;
    end else if (!en_i) begin
      in_cmd_o <= 1'b0;
    end else if (mode_i) begin
      if (sdi_i) begin
        in_cmd_o <= 1'b1;
      end else if (in_cmd_o) begin
        cmd_q_o  <= cmd_e'(cmd_sr);
        in_cmd_o <= 1'b0;
      end
    end else if (in_cmd_o) begin
      cmd_sr <= {sdi_i, cmd_sr[CMD_W-1:1]};
    end
  end

  // a command just shifted in executes on the same edge that latches it
  assign exec_cmd_o = in_cmd_o ? cmd_e'(cmd_sr) : cmd_q_o;
  assign exec_o     = en_i & mode_i & ~sdi_i;
  assign shift_o    = en_i & ~mode_i & ~in_cmd_o;
  assign cmd_bit_o  = cmd_sr[0];
endmodule

// File: rtl/isp_shift_regs.sv
`timescale 1ns/1ps
module isp_shift_regs
  import isp_cfg_pkg::*;
#(
  parameter int          ROWS   = 110,
  parameter int          DATA_W = 160,
  parameter int          ID_W   = 8,
  parameter logic [ID_W-1:0] DEV_ID = 8'h0B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  cmd_e              sel_cmd_i,
  input  logic              exec_i,
  input  cmd_e              exec_cmd_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_row_i,
  output logic [ROWS-1:0]   addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ser_bit_o
);
  localparam int HALF = DATA_W / 2;

  logic [ID_W-1:0] id_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      id_sr  <= '0;
    end else if (exec_i) begin
      case (exec_cmd_i)
        CMD_VERIFY: data_o <= rd_row_i;
        CMD_ID:     id_sr  <= DEV_ID;
        default:    ;
      endcase
    end else if (shift_i) begin
      case (sel_cmd_i)
        CMD_ADDR: addr_o <= {sdi_i, addr_o[ROWS-1:1]};
        CMD_DLO:  data_o[HALF-1:0] <= {sdi_i, data_o[HALF-1:1]};
        CMD_DHI:  data_o[DATA_W-1:HALF] <= {sdi_i, data_o[DATA_W-1:HALF+1]};
        CMD_DALL: data_o <= {sdi_i, data_o[DATA_W-1:1]};
        CMD_ID:   id_sr  <= {sdi_i, id_sr[ID_W-1:1]};
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel_cmd_i)
      CMD_ADDR:         ser_bit_o = addr_o[0];
      CMD_DLO, CMD_DALL: ser_bit_o = data_o[0];
      CMD_DHI:          ser_bit_o = data_o[HALF];
      CMD_ID:           ser_bit_o = id_sr[0];
      default:          ser_bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/isp_row_array.sv
`timescale 1ns/1ps
module isp_row_array #(
  parameter int ROWS   = 110,
  parameter int DATA_W = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ROWS-1:0]   sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else if (wr_i) begin
      for (int r = 0; r < ROWS; r++)
        if (sel_i[r]) mem_q[r] <= wdata_i;
    end
  end

  // wired-AND readback across every enabled row
  always_comb begin
    rdata_o = '1;
    for (int r = 0; r < ROWS; r++)
      if (sel_i[r]) rdata_o = rdata_o & mem_q[r];
  end
endmodule

// File: rtl/isp_serial_port.sv
`timescale 1ns/1ps
module isp_serial_port
  import isp_cfg_pkg::*;
#(
  parameter int          ROWS   = 110,
  parameter int          DATA_W = 160,
  parameter int          ID_W   = 8,
  parameter logic [ID_W-1:0] DEV_ID = 8'h0B
) (
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       ispen_ni,
  input  logic       mode_i,
  input  logic       sdi_i,
  output logic       sdo_o,
  output logic       sdo_oe_o,
  output logic [1:0] pin_o
);
  logic              en;
  logic              in_cmd, exec, shift, cmd_bit, ser_bit, sdo_q;
  cmd_e              cmd_q, exec_cmd;
  logic [ROWS-1:0]   addr_q;
  logic [DATA_W-1:0] data_q, rd_row;

  assign en = ~ispen_ni;

  isp_cmd_fsm u_fsm (
    .clk_i      (sclk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .mode_i     (mode_i),
    .sdi_i      (sdi_i),
    .in_cmd_o   (in_cmd),
    .cmd_q_o    (cmd_q),
    .exec_cmd_o (exec_cmd),
    .exec_o     (exec),
    .shift_o    (shift),
    .cmd_bit_o  (cmd_bit)
  );

  isp_shift_regs #(
    .ROWS(ROWS), .DATA_W(DATA_W), .ID_W(ID_W), .DEV_ID(DEV_ID)
  ) u_regs (
    .clk_i      (sclk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .sel_cmd_i  (cmd_q),
    .exec_i     (exec),
    .exec_cmd_i (exec_cmd),
    .sdi_i      (sdi_i),
    .rd_row_i   (rd_row),
    .addr_o     (addr_q),
    .data_o     (data_q),
    .ser_bit_o  (ser_bit)
  );

  isp_row_array #(.ROWS(ROWS), .DATA_W(DATA_W)) u_array (
    .clk_i   (sclk_i),
    .rst_ni  (rst_ni),
    .wr_i    (exec && exec_cmd == CMD_PROG),
    .sel_i   (addr_q),
    .wdata_i (data_q),
    .rdata_o (rd_row)
  );

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)     sdo_q <= 1'b0;
    else if (!en)    sdo_q <= 1'b0;
    else             sdo_q <= in_cmd ? cmd_bit : ser_bit;
  end

  assign sdo_o    = en & sdo_q;
  assign sdo_oe_o = en;
  assign pin_o    = ispen_ni ? {mode_i, sdi_i} : 2'b00;
endmodule

// File: rtl/isp_serial_port_chk.sv
`timescale 1ns/1ps
module isp_serial_port_chk
  import isp_cfg_pkg::*;
#(
  parameter int ROWS   = 110,
  parameter int DATA_W = 160
) (
  input logic              rst_ni,
  input logic              sclk_i,
  input logic              ispen_ni,
  input logic              mode_i,
  input logic              sdi_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              in_cmd,
  input cmd_e              cmd_q,
  input cmd_e              exec_cmd,
  input logic [ROWS-1:0]   addr_q,
  input logic [DATA_W-1:0] data_q
);
  localparam int HALF = DATA_W / 2;

  // R3
  cmd_enter_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!ispen_ni && mode_i && sdi_i) |=> in_cmd);

  // R3
  cmd_latch_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!ispen_ni && mode_i && !sdi_i && in_cmd) |=> (!in_cmd && cmd_q == $past(exec_cmd)));

  // R4
  addr_shift_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!ispen_ni && !mode_i && !in_cmd && cmd_q == CMD_ADDR) |=>
      (addr_q[ROWS-1] == $past(sdi_i) && addr_q[ROWS-2:0] == $past(addr_q[ROWS-1:1])));

  // R5
  lo_half_only_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!ispen_ni && !mode_i && !in_cmd && cmd_q == CMD_DLO) |=> $stable(data_q[DATA_W-1:HALF]));

  // R5
  hi_half_only_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    (!ispen_ni && !mode_i && !in_cmd && cmd_q == CMD_DHI) |=> $stable(data_q[HALF-1:0]));

  // R2
  idle_hold_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    ispen_ni |=> ($stable(addr_q) && $stable(data_q) && !in_cmd));

  // R2
  idle_quiet_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    ispen_ni |-> (!sdo_oe_o && !sdo_o));
endmodule

bind isp_serial_port isp_serial_port_chk #(.ROWS(ROWS), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/isp_serial_port_tb.sv
`timescale 1ns/1ps
module isp_serial_port_tb;
  localparam int ROWS = 110;
  localparam int DW   = 160;
  localparam int HW   = DW / 2;

  logic rst_ni = 1'b0, sclk_i = 1'b0, ispen_ni = 1'b1, mode_i = 1'b0, sdi_i = 1'b0;
  logic sdo_o, sdo_oe_o;
  logic [1:0] pin_o;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [DW-1:0] mdl [ROWS];

  isp_serial_port u_dut (
    .rst_ni(rst_ni), .sclk_i(sclk_i), .ispen_ni(ispen_ni), .mode_i(mode_i),
    .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .pin_o(pin_o)
  );

  always #10 sclk_i = ~sclk_i;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic s);
    mode_i = m; sdi_i = s;
    @(posedge sclk_i); @(negedge sclk_i); #2;
  endtask

  task automatic send_cmd(input logic [2:0] c);
    step(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, c[i]);
    step(1'b1, 1'b0);
  endtask

  task automatic load(input int n, input logic [DW-1:0] v);
    for (int i = 0; i < n; i++) step(1'b0, v[i]);
  endtask

  task automatic read(input int n, output logic [DW-1:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin v[i] = sdo_o; step(1'b0, 1'b0); end
  endtask

  task automatic program_rows(input logic [ROWS-1:0] sel, input logic [DW-1:0] d);
    send_cmd(3'd1); load(ROWS, DW'(sel));
    send_cmd(3'd7); load(DW, d);
    send_cmd(3'd3);
    for (int r = 0; r < ROWS; r++) if (sel[r]) mdl[r] = d;
  endtask

  task automatic verify_rows(input logic [ROWS-1:0] sel, output logic [DW-1:0] v);
    send_cmd(3'd1); load(ROWS, DW'(sel));
    send_cmd(3'd4); send_cmd(3'd7); read(DW, v);
  endtask

  function automatic logic [DW-1:0] rvec();
    logic [DW-1:0] r;
    for (int k = 0; k < DW / 32; k++) r[k*32 +: 32] = $urandom();
    return r;
  endfunction

  function automatic logic [ROWS-1:0] onehot(input int r);
    logic [ROWS-1:0] v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [DW-1:0] and_rows(input logic [ROWS-1:0] sel);
    logic [DW-1:0] res = '1;
    for (int r = 0; r < ROWS; r++) if (sel[r]) res &= mdl[r];
    return res;
  endfunction

  initial begin
    repeat (150000) @(posedge sclk_i);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, w, x, y;
    logic [ROWS-1:0] sel;
    int ra, rb;
    void'($urandom(32'h1C0FFEE));
    for (int r = 0; r < ROWS; r++) mdl[r] = '0;
    #1;
    chk("R1 sdo in reset", DW'(sdo_o), '0);
    repeat (3) @(negedge sclk_i);
    rst_ni = 1'b1;
    #2;
    // R2 pass-through while disabled
    mode_i = 1'b1; sdi_i = 1'b0; #1;
    chk("R2 pin_o pass", DW'(pin_o), DW'(2'b10));
    chk("R2 sdo_oe off", DW'({sdo_oe_o, sdo_o}), '0);
    mode_i = 1'b0; sdi_i = 1'b1; #1;
    chk("R2 pin_o pass", DW'(pin_o), DW'(2'b01));

    ispen_ni = 1'b0; #1;
    chk("R2 pin_o zero when enabled", DW'({pin_o, sdo_oe_o}), DW'(3'b001));

    // R8 identifier
    send_cmd(3'd5); read(8, v);
    chk("R8 identifier", v, DW'(8'h0B));

    // R1 array cleared by reset
    verify_rows(onehot(5), v);
    chk("R1 row cleared", v, '0);

    // R9 falling-edge update: id bits 1 and 2 are 1 then 0
    send_cmd(3'd5); step(1'b0, 1'b0);
    mode_i = 1'b0; sdi_i = 1'b0;
    @(posedge sclk_i); #2;
    chk("R9 sdo held past rising edge", DW'(sdo_o), DW'(1'b1));
    @(negedge sclk_i); #2;
    chk("R9 sdo after falling edge", DW'(sdo_o), DW'(1'b0));

    // R4 address register readback, LSB first
    sel = onehot(0) | onehot(ROWS - 1) | onehot(37);
    send_cmd(3'd1); load(ROWS, DW'(sel)); read(ROWS, v);
    chk("R4 address readback", v, DW'(sel));

    // R6/R4 random single-row program then verify
    for (int it = 0; it < 6; it++) begin
      ra = int'($urandom_range(ROWS - 1));
      w  = rvec();
      program_rows(onehot(ra), w);
      verify_rows(onehot(ra), v);
      chk("R6 single row program", v, w);
    end

    // R6 multi-row write, R7 AND readback
    ra = 12; rb = 90;
    w = rvec();
    program_rows(onehot(ra) | onehot(rb), w);
    verify_rows(onehot(rb), v);
    chk("R6 both selected rows written", v, w);
    x = rvec();
    program_rows(onehot(ra), x);
    verify_rows(onehot(rb), v);
    chk("R6 unselected row kept", v, mdl[rb]);
    verify_rows(onehot(ra) | onehot(rb), v);
    chk("R7 AND of selected rows", v, and_rows(onehot(ra) | onehot(rb)));
    verify_rows('0, v);
    chk("R7 no row selected", v, '1);

    // R5 low half only
    x = rvec(); y = rvec();
    send_cmd(3'd7); load(DW, x);
    send_cmd(3'd2); load(HW, y);
    send_cmd(3'd7); read(DW, v);
    chk("R5 low half shift", v, {x[DW-1:HW], y[HW-1:0]});
    // R5 high half only, and R9 high-half tap at bit 80
    x = rvec(); y = rvec();
    send_cmd(3'd7); load(DW, x);
    send_cmd(3'd6); load(DW - HW, y);
    chk("R9 high-half tap", DW'(sdo_o), DW'(y[0]));
    send_cmd(3'd7); read(DW, v);
    chk("R5 high half shift", v, {y[DW-HW-1:0], x[HW-1:0]});

    // R3 no-op leaves data register
    w = rvec();
    send_cmd(3'd7); load(DW, w);
    send_cmd(3'd0); load(8, rvec());
    send_cmd(3'd7); read(DW, v);
    chk("R3 no-op no effect", v, w);

    // R2 inputs ignored while disabled
    w = rvec();
    send_cmd(3'd7); load(DW, w);
    ispen_ni = 1'b1;
    for (int i = 0; i < 24; i++) step(1'($urandom()), 1'($urandom()));
    chk("R2 sdo quiet while disabled", DW'({sdo_oe_o, sdo_o}), '0);
    ispen_ni = 1'b0;
    send_cmd(3'd7); read(DW, v);
    chk("R2 data held while disabled", v, w);
    verify_rows(onehot(ra), v);
    chk("R2 array held while disabled", v, mdl[ra]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule